// File: doc/BRIEF.md
# Two-Level Context-Switched Address Translator

This block turns a 21-bit CPU virtual address into a 21-bit physical address in two lookups. First, a section number and the top address bits index a segment map. The section number comes from a small context register. The segment map returns a pointer into the page map. Second, that pointer and the middle address bits index the page map, which returns a physical page number and three protection flags. The low eleven address bits, the offset within a 2 KB page, are carried through unchanged. A segment covers 32 KB, or sixteen pages, so each context spans 2 MB of logical space.

Software, or a boot sequencer, fills both maps and the control register through a write-only configuration port. Switching address spaces only rewrites the control register; no map entry is touched. Two contexts share memory when their map entries hold the same values. An optional split mode gives supervisor accesses their own 3-bit context and user accesses another. The maps are not cleared by reset, so every entry must be written before it is used.

Translation runs as a four-state machine. `ST_IDLE` accepts a request and moves to `ST_SEG`. `ST_SEG` reads the segment map and moves to `ST_PAGE`. `ST_PAGE` reads the page map and moves to `ST_RESP`. `ST_RESP` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `mmu_segpage`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, and the control register selects context 0 with split mode off.
- R2: The virtual address splits into offset [10:0], page index [14:11] and segment [20:15]. A successful translation returns `{ppn, offset}`, so the offset passes through unchanged. This holds for the last page of a segment as well as the first.
- R3: With split mode off, the section number equals the 4-bit context field, for user and supervisor accesses alike.
- R4: Writing a new context value redirects the following translations to that context's segment map section, with no map entry rewritten.
- R5: Two contexts whose segment entries hold the same page-map pointer translate to the same physical address.
- R6: A page entry whose valid bit (bit 12) is 0 gives `resp_fault` = 1 and `resp_pa` = 0.
- R7: A write to a page whose write-enable bit (bit 11) is 0 faults. A read of that page, or a write to a page with the bit set, does not fault.
- R8: A user access (`req_super` = 0) to a page whose supervisor-only bit (bit 10) is 1 faults. A supervisor access to that page does not.
- R9: With the split bit (control bit 7) set, a supervisor access uses section `{1, sys_ctx}`, where sys_ctx is control bits [6:4]. A user access uses section `{0, ctx[2:0]}`.
- R10: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `resp_valid` rises exactly three edges later and stays high for one cycle. `req_ready` is 0 from the accepting edge until the response cycle ends. A request presented while busy is ignored.
- R11: `cfg_sel` encodes 0 = control register (ctx [3:0], sys_ctx [6:4], split [7]), 1 = segment entry at `cfg_addr` = {section, segment} (pointer in [5:0]), and 2 = page entry at `cfg_addr` = {pointer, page index} (ppn [9:0] plus the flags above). The value 3 writes nothing.
- R12: The section is captured when the request is accepted. A control register write during a translation affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle and able to take a request |
| req_addr | input | 21 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_super | input | 1 | 1 = supervisor state, 0 = user |
| resp_valid | output | 1 | Result available this cycle |
| resp_pa | output | 21 | Physical address, zero on a fault |
| resp_fault | output | 1 | Access refused |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: control, segment, page, none |
| cfg_addr | input | 10 | Map entry index |
| cfg_wdata | input | 13 | Write data |

## Verification
The bench targets the edges of the address split. It covers offset 0x7FF and page index 15, where a design that shifted or truncated a field would return the wrong frame or a corrupted offset. It also changes context in the middle of a translation and keeps a second request asserted while the translator is busy; a design without a captured section would pick up the new context, and one with leaky handshaking would answer for the wrong address. The protection cases combine each flag with both access kinds, including split mode, where swapped section halves would send supervisor and user accesses to each other's maps.

// File: rtl/mmu_segpage_pkg.sv
package mmu_segpage_pkg;

    // Translation sequence: accept, segment read, page read, respond
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_PAGE = 2'd2,
        ST_RESP = 2'd3
    } xlat_state_e;

    // Configuration write targets
    localparam logic [1:0] CFG_CTRL = 2'd0;
    localparam logic [1:0] CFG_SEG  = 2'd1;
    localparam logic [1:0] CFG_PAGE = 2'd2;

endpackage

// File: rtl/mmu_ctx_sel.sv
module mmu_ctx_sel #(
    parameter int CTX_W    = 4,
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic [CTX_W-1:0] ctx_num,
    input  logic [CTX_W-2:0] sys_ctx,
    input  logic             split,
    input  logic             is_super,
    output logic [CTX_W-1:0] section
);

    generate
        if (SPLIT_EN) begin : g_split
            always_comb begin
                if (split) begin
                    section = {is_super, (is_super ? sys_ctx : ctx_num[CTX_W-2:0])};
                end else begin
                    section = ctx_num;
                end
            end
        end else begin : g_flat
            logic unused_split;
            assign unused_split = split ^ is_super ^ (^sys_ctx);
            assign section = ctx_num;
        end
    endgenerate

endmodule

// File: rtl/mmu_map_ram.sv
module mmu_map_ram #(
    parameter int AW = 10,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/mmu_prot_chk.sv
module mmu_prot_chk #(
    parameter int PPN_W = 10
) (
    input  logic [PPN_W+2:0] pte,
    input  logic             is_write,
    input  logic             is_super,
    output logic             fault,
    output logic [PPN_W-1:0] ppn
);

    logic ent_valid;
    logic ent_wr_ok;
    logic ent_sup;

    assign ent_valid = pte[PPN_W+2];
    assign ent_wr_ok = pte[PPN_W+1];
    assign ent_sup   = pte[PPN_W];
    assign ppn       = pte[PPN_W-1:0];

    always_comb begin
        fault = 1'b0;
        if (!ent_valid)               fault = 1'b1;
        if (is_write && !ent_wr_ok)   fault = 1'b1;
        if (!is_super && ent_sup)     fault = 1'b1;
    end

endmodule

// File: rtl/mmu_segpage.sv
module mmu_segpage
    import mmu_segpage_pkg::*;
#(
    parameter int OFFS_W   = 11,
    parameter int PIDX_W   = 4,
    parameter int SEG_W    = 6,
    parameter int CTX_W    = 4,
    parameter int PTR_W    = 6,
    parameter int PPN_W    = 10,
    parameter bit SPLIT_EN = 1'b1,
    localparam int VA_W    = OFFS_W + PIDX_W + SEG_W,
    localparam int PA_W    = PPN_W + OFFS_W,
    localparam int SMAP_AW = CTX_W + SEG_W,
    localparam int PMAP_AW = PTR_W + PIDX_W,
    localparam int PTE_W   = PPN_W + 3,
    localparam int CFG_AW  = (SMAP_AW > PMAP_AW) ? SMAP_AW : PMAP_AW,
    localparam int CFG_DW  = (PTE_W > 2*CTX_W) ? PTE_W : 2*CTX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic              req_super,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_pa,
    output logic              resp_fault,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata
);

    xlat_state_e state_q, state_d;

    logic [CTX_W-1:0]  ctx_q;
    logic [CTX_W-2:0]  sys_ctx_q;
    logic              split_q;

    logic [CTX_W-1:0]  sect_q;
    logic [SEG_W-1:0]  seg_q;
    logic [PIDX_W-1:0] pidx_q;
    logic [OFFS_W-1:0] offs_q;
    logic              wr_q;
    logic              sup_q;

    logic              accept;
    logic [CTX_W-1:0]  section_w;
    logic [PTR_W-1:0]  ptr_w;
    logic [PTE_W-1:0]  pte_w;
    logic              fault_w;
    logic [PPN_W-1:0]  ppn_w;
    logic              pte_we;
    logic              pte_sup;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign pte_we  = pte_w[PPN_W+1];
    assign pte_sup = pte_w[PPN_W];

    // Control register: context, supervisor context, split mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q     <= '0;
            sys_ctx_q <= '0;
            split_q   <= 1'b0;
        end else if (cfg_we && (cfg_sel == CFG_CTRL)) begin
            ctx_q     <= cfg_wdata[CTX_W-1:0];
            sys_ctx_q <= cfg_wdata[2*CTX_W-2:CTX_W];
            split_q   <= cfg_wdata[2*CTX_W-1];
        end
    end

    mmu_ctx_sel #(
        .CTX_W    (CTX_W),
        .SPLIT_EN (SPLIT_EN)
    ) u_ctx_sel (
        .ctx_num  (ctx_q),
        .sys_ctx  (sys_ctx_q),
        .split    (split_q),
        .is_super (req_super),
        .section  (section_w)
    );

    // Request capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sect_q <= '0;
            seg_q  <= '0;
            pidx_q <= '0;
            offs_q <= '0;
            wr_q   <= 1'b0;
            sup_q  <= 1'b0;
        end else if (accept) begin
            sect_q <= section_w;
            seg_q  <= req_addr[VA_W-1 -: SEG_W];
            pidx_q <= req_addr[OFFS_W +: PIDX_W];
            offs_q <= req_addr[OFFS_W-1:0];
            wr_q   <= req_write;
            sup_q  <= req_super;
        end
    end

    mmu_map_ram #(
        .AW (SMAP_AW),
        .DW (PTR_W)
    ) u_seg_map (
        .clk   (clk),
        .we    (cfg_we && (cfg_sel == CFG_SEG)),
        .waddr (cfg_addr[SMAP_AW-1:0]),
        .wdata (cfg_wdata[PTR_W-1:0]),
        .raddr ({sect_q, seg_q}),
        .rdata (ptr_w)
    );

    mmu_map_ram #(
        .AW (PMAP_AW),
        .DW (PTE_W)
    ) u_page_map (
        .clk   (clk),
        .we    (cfg_we && (cfg_sel == CFG_PAGE)),
        .waddr (cfg_addr[PMAP_AW-1:0]),
        .wdata (cfg_wdata[PTE_W-1:0]),
        .raddr ({ptr_w, pidx_q}),
        .rdata (pte_w)
    );

    mmu_prot_chk #(
        .PPN_W (PPN_W)
    ) u_prot (
        .pte      (pte_w),
        .is_write (wr_q),
        .is_super (sup_q),
        .fault    (fault_w),
        .ppn      (ppn_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_SEG;
            ST_SEG:  state_d = ST_PAGE;
            ST_PAGE: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
        resp_fault = resp_valid && fault_w;
        resp_pa    = (resp_valid && !fault_w) ? {ppn_w, offs_q} : '0;
    end

endmodule

// File: rtl/mmu_segpage_chk.sv
module mmu_segpage_chk #(
    parameter int OFFS_W = 11,
    parameter int VA_W   = 21,
    parameter int PA_W   = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_addr,
    input logic            req_write,
    input logic            req_super,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_pa,
    input logic            resp_fault,
    input logic            pte_we,
    input logic            pte_sup
);

    a_r10_one_cycle_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r10_three_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready, 3));

    a_r10_busy_while_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    a_r6_fault_blanks_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_pa == '0));

    a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_pa[OFFS_W-1:0] == $past(req_addr[OFFS_W-1:0], 3)));

    a_r7_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault && $past(req_write, 3)) |-> pte_we);

    a_r8_user_not_sup_page: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault && !$past(req_super, 3)) |-> !pte_sup);

endmodule

bind mmu_segpage mmu_segpage_chk #(
    .OFFS_W (OFFS_W),
    .VA_W   (VA_W),
    .PA_W   (PA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_super  (req_super),
    .resp_valid (resp_valid),
    .resp_pa    (resp_pa),
    .resp_fault (resp_fault),
    .pte_we     (pte_we),
    .pte_sup    (pte_sup)
);

// File: tb/mmu_segpage_tb_top.sv
module mmu_segpage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [20:0] req_addr;
    logic        req_write;
    logic        req_super;
    logic        resp_valid;
    logic [20:0] resp_pa;
    logic        resp_fault;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [9:0]  cfg_addr;
    logic [12:0] cfg_wdata;

    always #2 clk = ~clk;

    mmu_segpage dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_super  (req_super),
        .resp_valid (resp_valid),
        .resp_pa    (resp_pa),
        .resp_fault (resp_fault),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference state
    int seg_m [1024];
    int pg_m  [1024];
    int m_ctx   = 0;
    int m_sys   = 0;
    bit m_split = 1'b0;

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic cfg_write(logic [1:0] sel, int addr, int data);
        cfg_sel   = sel;
        cfg_addr  = addr[9:0];
        cfg_wdata = data[12:0];
        cfg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: begin m_ctx = data & 15; m_sys = (data >> 4) & 7; m_split = data[7]; end
            2'd1: seg_m[addr] = data & 63;
            2'd2: pg_m[addr]  = data & 13'h1FFF;
            default: ;
        endcase
    endtask

    function automatic void model(logic [20:0] va, bit wr, bit sup,
                                  output logic [20:0] pa, output bit flt);
        int sect;
        int ptr;
        int pe;
        if (m_split) sect = sup ? (8 + m_sys) : (m_ctx % 8);
        else         sect = m_ctx;
        ptr = seg_m[sect * 64 + int'(va[20:15])];
        pe  = pg_m[ptr * 16 + int'(va[14:11])];
        flt = !pe[12] || (wr && !pe[11]) || (!sup && pe[10]);
        pa  = flt ? 21'd0 : {pe[9:0], va[10:0]};
    endfunction

    // mode 0: plain; 1: keep another request asserted while busy; 2: context write in flight
    task automatic access(logic [20:0] va, bit wr, bit sup, string tag, int mode);
        logic [20:0] epa;
        bit          eflt;
        while (!req_ready) @(negedge clk);
        req_addr  = va;
        req_write = wr;
        req_super = sup;
        req_valid = 1'b1;
        model(va, wr, sup, epa, eflt);
        @(posedge clk);
        @(negedge clk);
        check(!req_ready && !resp_valid, "R10", "busy after accept", {resp_valid, req_ready}, 0);
        if (mode == 1) begin
            req_addr  = va ^ 21'h1F_F800;
            req_write = ~wr;
            req_super = ~sup;
        end else begin
            req_valid = 1'b0;
        end
        if (mode == 2) begin
            cfg_sel = 2'd0; cfg_addr = '0; cfg_wdata = 13'h005; cfg_we = 1'b1;
        end
        @(negedge clk);
        if (mode == 2) begin
            cfg_we = 1'b0;
            m_ctx  = 5;
        end
        check(!resp_valid && !req_ready, "R10", "no response yet", {resp_valid, req_ready}, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid && !req_ready, "R10", "response cycle", {resp_valid, req_ready}, 2);
        check(resp_pa == epa && resp_fault == eflt, tag, "translation",
              {resp_fault, resp_pa}, {eflt, epa});
    endtask

    function automatic logic [20:0] va_of(int seg, int pidx, int offs);
        return {seg[5:0], pidx[3:0], offs[10:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_super = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_addr = '0; cfg_wdata = '0;
        foreach (seg_m[i]) seg_m[i] = 0;
        foreach (pg_m[i])  pg_m[i]  = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid, "R1", "reset outputs", {resp_valid, req_ready}, 1);

        // R11: segment entries at {section, segment}
        cfg_write(2'd1, 0 * 64 + 0,  1);
        cfg_write(2'd1, 0 * 64 + 63, 2);
        cfg_write(2'd1, 5 * 64 + 0,  3);
        cfg_write(2'd1, 9 * 64 + 2,  1);
        cfg_write(2'd1, 2 * 64 + 0,  4);
        cfg_write(2'd1, 11 * 64 + 0, 5);
        cfg_write(2'd1, 0 * 64 + 2,  6);
        // R11: page entries at {pointer, page index}: valid 12, write 11, sup 10, ppn 9:0
        cfg_write(2'd2, 1 * 16 + 0,  13'h1800 | 13'h123);
        cfg_write(2'd2, 1 * 16 + 15, 13'h1000 | 13'h3FF);
        cfg_write(2'd2, 2 * 16 + 7,  13'h1C00 | 13'h055);
        cfg_write(2'd2, 3 * 16 + 0,  13'h1800 | 13'h2AA);
        cfg_write(2'd2, 1 * 16 + 1,  13'h0C1F);
        cfg_write(2'd2, 4 * 16 + 0,  13'h1800 | 13'h0F0);
        cfg_write(2'd2, 5 * 16 + 0,  13'h1C00 | 13'h300);
        cfg_write(2'd2, 6 * 16 + 0,  13'h0000);

        // R1: control never written, so context 0 applies
        access(va_of(0, 0, 11'h7FF), 1'b0, 1'b0, "R1", 0);
        access(va_of(0, 15, 0), 1'b0, 1'b1, "R2", 0);
        access(va_of(0, 0, 11'h2A5), 1'b0, 1'b1, "R3", 0);
        access(va_of(0, 15, 11'h001), 1'b1, 1'b1, "R7", 0);
        access(va_of(0, 15, 11'h001), 1'b0, 1'b0, "R7", 0);
        access(va_of(0, 0, 11'h010), 1'b1, 1'b0, "R7", 0);
        access(va_of(63, 7, 11'h400), 1'b0, 1'b0, "R8", 0);
        access(va_of(63, 7, 11'h400), 1'b1, 1'b1, "R8", 0);
        access(va_of(0, 1, 11'h123), 1'b0, 1'b1, "R6", 0);

        cfg_write(2'd0, 0, 5);
        access(va_of(0, 0, 11'h010), 1'b0, 1'b0, "R4", 0);
        access(va_of(0, 0, 11'h011), 1'b1, 1'b1, "R3", 0);

        cfg_write(2'd0, 0, 9);
        access(va_of(2, 0, 11'h055), 1'b0, 1'b0, "R5", 0);

        // R11: target 3 writes nothing; context 9 stays in force
        cfg_write(2'd3, 0, 0);
        access(va_of(2, 0, 11'h056), 1'b0, 1'b0, "R11", 0);

        // R9: split on, sys_ctx 3, user ctx 2
        cfg_write(2'd0, 0, 13'h0B2);
        access(va_of(0, 0, 11'h0AB), 1'b0, 1'b1, "R9", 0);
        access(va_of(0, 0, 11'h0AC), 1'b1, 1'b0, "R9", 0);

        cfg_write(2'd0, 0, 0);
        access(va_of(0, 0, 11'h321), 1'b0, 1'b0, "R12", 2);
        access(va_of(0, 0, 11'h322), 1'b0, 1'b0, "R12", 0);

        cfg_write(2'd0, 0, 0);
        access(va_of(0, 0, 11'h0F0), 1'b1, 1'b0, "R10", 1);
        @(negedge clk);
        check(req_ready && !resp_valid, "R10", "idle after response", {resp_valid, req_ready}, 1);

        summary();
    end

endmodule